// File: doc/BRIEF.md
# Four-Way Data Cache Controller

This block is a 16 KB data cache. It sits between a single load/store request port and a memory port that moves either one word or a whole 32-byte line. The cache is indexed and tagged with physical addresses. It holds 128 sets of four ways, and each line is eight 32-bit words. Every line carries a tag and a two-bit coherence state that is Invalid, Exclusive or Modified. Dirty tracking is folded into that state, so there is no separate valid or dirty flag.

Each request carries attributes chosen per page:
- A write-through flag, which selects how writes behave.
- A caching-inhibited flag, which sends the access straight to memory.

On a miss the controller picks a victim way. It writes the victim back if the victim is Modified, refills the line with a burst and then replays the lookup. A one-cycle invalidate pulse sweeps every set to Invalid while the request port is held off.

Top module: `dcache_top`

## Requirements
- R1: Byte address bits [4:2] select the word in a line, bits [11:5] select one of 128 sets, and bits [31:12] form the tag. Addresses that differ only in the tag share a set and live in different ways.
- R2: A cacheable read miss fills the line in Exclusive state and then returns the word. Memory protocol for a burst:
  - mem_req_o stays high and mem_burst_o is high.
  - mem_addr_o shows the current word, starting at the line base and rising by 4 each beat.
  - One beat completes in each cycle that mem_ack_i is high.
  - There are eight beats.
- R3: A cacheable read hit raises resp_valid_o exactly two cycles after the accepting clock edge, with no memory traffic.
- R4: A write hit without the write-through flag updates the word, makes the line Modified and issues no memory access.
- R5: A write with the write-through flag performs one single-beat memory write (mem_burst_o low). On a hit it also updates the cached word, and the line keeps its coherence state.
- R6: A write miss without write-through allocates: it fills the line and then merges the word, leaving the line Modified. A write miss with write-through does not allocate.
- R7: A caching-inhibited access does one single-beat memory access at the request address and leaves the cache contents untouched.
- R8: When a set has an Invalid way, the victim is the lowest-numbered Invalid way.
- R9: With no Invalid way, a 3-bit tree per set picks the victim:
  - Bit 0 selects the pair: 0 means ways 0/1, 1 means ways 2/3.
  - Bit 1 selects between way 0 (0) and way 1 (1).
  - Bit 2 selects between way 2 (0) and way 3 (1).
  - Every hit sets the bits to point away from the way that hit.
- R10: A Modified victim is written back as an 8-beat burst to its own line address, and the refill burst follows immediately. An Exclusive victim causes no writeback.
- R11: An inv_i pulse holds req_ready_o low for 128 cycles, one set per cycle, and leaves every line Invalid. Modified data is discarded without any writeback.
- R12: After reset every line is Invalid, req_ready_o is high, and mem_req_o and resp_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inv_i | input | 1 | One-cycle request to invalidate the whole cache |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on a clock edge when this is high together with req_valid_i |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wt_i | input | 1 | Write-through attribute |
| req_ci_i | input | 1 | Caching-inhibited attribute |
| req_addr_i | input | 32 | Byte address, word aligned |
| req_wdata_i | input | 32 | Write data |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_rdata_o | output | 32 | Read data, valid with resp_valid_o |
| mem_req_o | output | 1 | Memory transfer in progress |
| mem_we_o | output | 1 | Memory transfer is a write |
| mem_burst_o | output | 1 | Transfer is an 8-beat line burst |
| mem_addr_o | output | 32 | Byte address of the current beat |
| mem_wdata_o | output | 32 | Write data of the current beat |
| mem_ack_i | input | 1 | Current beat completes on this clock edge |
| mem_rdata_i | input | 32 | Read data of the current beat, valid with mem_ack_i |

## Verification
The checker watches the memory port on every cycle:
- Each burst walks up one word per acknowledged beat.
- A finished writeback burst is followed at once by a refill from a line base.
- A single-beat transfer always ends in a response.
- No memory traffic is seen while the port is ready or a response is given.
- An invalidate pulse always closes the request port.

Some behaviours can only be seen by the bench's scenarios, through data values and transfer logs:
- Victim choice under the tree.
- Which line states survive write-through.
- Allocation policy on write misses.
- Bypass of inhibited accesses.
- Loss of Modified data on invalidation.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int NWAYS = 4;  // tree victim logic assumes four ways

  typedef enum logic [1:0] {
    MEI_I = 2'b00,
    MEI_E = 2'b01,
    MEI_M = 2'b11
  } mei_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAG,
    S_WB,
    S_FILL,
    S_SGL,
    S_INV
  } st_e;
endpackage

// File: rtl/dcache_tags.sv
module dcache_tags
  import dcache_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAY_W-1:0] vic_way_o,
  output logic [TAG_W-1:0] vic_tag_o,
  output mei_e             vic_state_o,
  input  logic             wr_en_i,
  input  logic             wr_tag_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  mei_e             wr_state_i,
  input  logic             touch_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i
);
  logic [TAG_W-1:0] tag_q   [SETS][NWAYS];
  mei_e             state_q [SETS][NWAYS];
  logic [2:0]       plru_q  [SETS];

  logic [2:0]       plru, plru_nx;
  logic             inv_found;
  logic [WAY_W-1:0] inv_way, tree_way;

  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (state_q[idx_i][w] != MEI_I && tag_q[idx_i][w] == tag_i) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
      if (state_q[idx_i][w] == MEI_I && !inv_found) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
    end
  end

  // bit0: pair select, bit1: way0/1, bit2: way2/3
  assign plru        = plru_q[idx_i];
  assign tree_way    = plru[0] ? {1'b1, plru[2]} : {1'b0, plru[1]};
  assign vic_way_o   = inv_found ? inv_way : tree_way;
  assign vic_tag_o   = tag_q[idx_i][vic_way_o];
  assign vic_state_o = state_q[idx_i][vic_way_o];
  assign plru_nx     = hit_way_o[1] ? {~hit_way_o[0], plru[1], 1'b0}
                                    : {plru[2], ~hit_way_o[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        plru_q[s] <= '0;
        for (int w = 0; w < NWAYS; w++) state_q[s][w] <= MEI_I;
      end
    end else begin
      if (clr_i) begin
        plru_q[clr_idx_i] <= '0;
        for (int w = 0; w < NWAYS; w++) state_q[clr_idx_i][w] <= MEI_I;
      end
      if (wr_en_i) state_q[idx_i][wr_way_i] <= wr_state_i;
      if (touch_i) plru_q[idx_i] <= plru_nx;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_tag_i) tag_q[idx_i][wr_way_i] <= tag_i;
  end
endmodule

// File: rtl/dcache_data.sv
module dcache_data #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4096,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[raddr_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/dcache_top.sv
module dcache_top
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 128,
  parameter int WORDS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic              req_wt_i,
  input  logic              req_ci_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_burst_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(NWAYS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int DA_W   = IDX_W + WAY_W + OFF_W;

  st_e               st_q;
  logic              we_q, wt_q, ci_q, resp_q, inv_pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [WAY_W-1:0]  vway_q;
  logic [TAG_W-1:0]  vtag_q;
  logic [OFF_W-1:0]  beat_q;
  logic [IDX_W-1:0]  inv_cnt_q;

  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, last_beat, ack_fill, wr_hit;
  logic [WAY_W-1:0]  hit_way, vic_way;
  logic [TAG_W-1:0]  vic_tag;
  mei_e              vic_state;
  logic [DATA_W-1:0] rd_data;
  logic              d_we;
  logic [DA_W-1:0]   d_waddr, d_raddr;
  logic [DATA_W-1:0] d_wdata;

  assign off       = addr_q[BYTE_W +: OFF_W];
  assign idx       = addr_q[BYTE_W + OFF_W +: IDX_W];
  assign tag       = addr_q[ADDR_W-1 -: TAG_W];
  assign last_beat = beat_q == OFF_W'(WORDS - 1);
  assign ack_fill  = st_q == S_FILL && mem_ack_i;
  assign wr_hit    = st_q == S_TAG && !ci_q && hit && we_q;

  dcache_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (idx),
    .tag_i       (tag),
    .hit_o       (hit),
    .hit_way_o   (hit_way),
    .vic_way_o   (vic_way),
    .vic_tag_o   (vic_tag),
    .vic_state_o (vic_state),
    .wr_en_i     ((ack_fill && last_beat) || (wr_hit && !wt_q)),
    .wr_tag_i    (ack_fill && last_beat),
    .wr_way_i    (st_q == S_FILL ? vway_q : hit_way),
    .wr_state_i  (st_q == S_FILL ? MEI_E : MEI_M),
    .touch_i     (st_q == S_TAG && !ci_q && hit),
    .clr_i       (st_q == S_INV),
    .clr_idx_i   (inv_cnt_q)
  );

  assign d_we    = ack_fill || wr_hit;
  assign d_waddr = ack_fill ? {idx, vway_q, beat_q} : {idx, hit_way, off};
  assign d_wdata = ack_fill ? mem_rdata_i : wdata_q;
  assign d_raddr = st_q == S_WB ? {idx, vway_q, beat_q} : {idx, hit_way, off};

  dcache_data #(.DATA_W(DATA_W), .DEPTH(SETS * NWAYS * WORDS)) u_data (
    .clk_i   (clk_i),
    .we_i    (d_we),
    .waddr_i (d_waddr),
    .wdata_i (d_wdata),
    .raddr_i (d_raddr),
    .rdata_o (rd_data)
  );

  assign req_ready_o  = st_q == S_IDLE && !inv_pend_q && !inv_i;
  assign resp_valid_o = resp_q;
  assign resp_rdata_o = rdata_q;
  assign mem_req_o    = st_q == S_WB || st_q == S_FILL || st_q == S_SGL;
  assign mem_burst_o  = st_q == S_WB || st_q == S_FILL;
  assign mem_we_o     = st_q == S_WB || (st_q == S_SGL && we_q);
  assign mem_addr_o   = st_q == S_SGL ? addr_q
                      : {(st_q == S_WB ? vtag_q : tag), idx, beat_q, BYTE_W'(0)};
  assign mem_wdata_o  = st_q == S_WB ? rd_data : wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      we_q       <= 1'b0;
      wt_q       <= 1'b0;
      ci_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      resp_q     <= 1'b0;
      inv_pend_q <= 1'b0;
      vway_q     <= '0;
      vtag_q     <= '0;
      beat_q     <= '0;
      inv_cnt_q  <= '0;
    end else begin
      resp_q <= 1'b0;
      if (inv_i && st_q != S_IDLE) inv_pend_q <= 1'b1;
      unique case (st_q)
        S_IDLE: begin
          if (inv_i || inv_pend_q) begin
            st_q       <= S_INV;
            inv_cnt_q  <= '0;
            inv_pend_q <= 1'b0;
          end else if (req_valid_i) begin
            we_q    <= req_we_i;
            wt_q    <= req_wt_i;
            ci_q    <= req_ci_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            st_q    <= S_TAG;
          end
        end
        S_TAG: begin
          if (ci_q || (we_q && wt_q)) begin
            st_q <= S_SGL;
          end else if (hit) begin
            resp_q  <= 1'b1;
            rdata_q <= rd_data;
            st_q    <= S_IDLE;
          end else begin
            vway_q <= vic_way;
            vtag_q <= vic_tag;
            beat_q <= '0;
            st_q   <= vic_state == MEI_M ? S_WB : S_FILL;
          end
        end
        S_WB, S_FILL: begin
          if (mem_ack_i) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) st_q <= st_q == S_WB ? S_FILL : S_TAG;  // refill replays lookup
          end
        end
        S_SGL: begin
          if (mem_ack_i) begin
            resp_q  <= 1'b1;
            rdata_q <= mem_rdata_i;
            st_q    <= S_IDLE;
          end
        end
        S_INV: begin
          inv_cnt_q <= inv_cnt_q + 1'b1;
          if (inv_cnt_q == IDX_W'(SETS - 1)) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_chk.sv
module dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 2,
  parameter int OFF_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inv_i,
  input logic              req_ready_o,
  input logic              resp_valid_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_burst_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o
);
  a_r2_burst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_burst_o && mem_ack_i && mem_addr_o[BYTE_W +: OFF_W] != '1)
    |=> (mem_req_o && mem_burst_o &&
         mem_addr_o == $past(mem_addr_o) + ADDR_W'(1 << BYTE_W)));

  a_r10_wb_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_burst_o && mem_we_o && mem_ack_i && mem_addr_o[BYTE_W +: OFF_W] == '1)
    |=> (mem_req_o && mem_burst_o && !mem_we_o && mem_addr_o[BYTE_W +: OFF_W] == '0));

  a_r7_single_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_burst_o && mem_ack_i) |=> resp_valid_o);

  a_r3_resp_mem_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !mem_req_o);

  a_r12_ready_mem_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);

  a_r11_inv_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> !req_ready_o);
endmodule

bind dcache_top dcache_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .OFF_W(OFF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .inv_i        (inv_i),
  .req_ready_o  (req_ready_o),
  .resp_valid_o (resp_valid_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_burst_o  (mem_burst_o),
  .mem_ack_i    (mem_ack_i),
  .mem_addr_o   (mem_addr_o)
);

// File: tb/dcache_top_tb_top.sv
`timescale 1ns/1ps
module dcache_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_wt = 1'b0, req_ci = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_req, mem_we, mem_burst;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  dcache_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .inv_i(inv),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_wt_i(req_wt), .req_ci_i(req_ci),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_burst_o(mem_burst),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model
  logic [31:0] mem_m [logic [31:0]];
  int          n_log = 0;
  logic        log_we   [64];
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];

  function automatic logic [31:0] init_val(logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [31:0] rd_mem(logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return init_val(a);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        mem_ack = 1'b1;
        if (mem_we) mem_m[mem_addr] = mem_wdata;
        mem_rdata = rd_mem(mem_addr);
        if (n_log < 64) begin
          log_we[n_log]   = mem_we;
          log_addr[n_log] = mem_addr;
          log_data[n_log] = mem_wdata;
        end
        n_log++;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int wr_beats();
    int c = 0;
    for (int i = 0; i < n_log && i < 64; i++) if (log_we[i]) c++;
    return c;
  endfunction

  task automatic do_req(input logic we, input logic wt, input logic ci,
                        input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    n_log = 0;
    req_valid = 1'b1; req_we = we; req_wt = wt; req_ci = ci;
    req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 2000) begin @(negedge clk); lat++; end
    rd = resp_rdata;
  endtask

  task automatic rd_chk(input string rq, input logic [31:0] a,
                        input logic [31:0] exp, input int beats);
    logic [31:0] rd;
    int lat;
    do_req(1'b0, 1'b0, 1'b0, a, '0, rd, lat);
    check({rq, " data"}, rd, exp);
    check({rq, " beats"}, n_log, beats);
  endtask

  typedef struct packed {
    logic        we;
    logic        wt;
    logic        ci;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  emode;  // 0 none, 1 initial memory value, 2 literal
    logic [31:0] eval;
    logic [3:0]  beats;
    logic [3:0]  rid;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{1'b0, 1'b0, 1'b0, 32'h0000_00A0, 32'h0,         2'd1, 32'h0,         4'd8, 4'd2},  // R2 miss fill
    '{1'b0, 1'b0, 1'b0, 32'h0000_00A4, 32'h0,         2'd1, 32'h0,         4'd0, 4'd3},  // R3 hit
    '{1'b1, 1'b0, 1'b0, 32'h0000_00A8, 32'h1111_1111, 2'd0, 32'h0,         4'd0, 4'd4},  // R4 wb write hit
    '{1'b0, 1'b0, 1'b0, 32'h0000_00A8, 32'h0,         2'd2, 32'h1111_1111, 4'd0, 4'd4},
    '{1'b1, 1'b1, 1'b0, 32'h0000_00AC, 32'h2222_2222, 2'd0, 32'h0,         4'd1, 4'd5},  // R5 wt write hit
    '{1'b0, 1'b0, 1'b0, 32'h0000_00AC, 32'h0,         2'd2, 32'h2222_2222, 4'd0, 4'd5},
    '{1'b0, 1'b0, 1'b1, 32'h0000_00AC, 32'h0,         2'd2, 32'h2222_2222, 4'd1, 4'd7},  // R7 inhibited read
    '{1'b1, 1'b0, 1'b1, 32'h0000_00B0, 32'h3333_3333, 2'd0, 32'h0,         4'd1, 4'd7},  // R7 inhibited write
    '{1'b0, 1'b0, 1'b0, 32'h0000_00B0, 32'h0,         2'd1, 32'h0,         4'd0, 4'd7},  // R7 cache kept old word
    '{1'b0, 1'b0, 1'b0, 32'h0000_10A0, 32'h0,         2'd1, 32'h0,         4'd8, 4'd1},  // R1 same set new tag
    '{1'b0, 1'b0, 1'b0, 32'h0000_00A0, 32'h0,         2'd1, 32'h0,         4'd0, 4'd1},
    '{1'b1, 1'b1, 1'b0, 32'h3000_0100, 32'h4444_4444, 2'd0, 32'h0,         4'd1, 4'd6},  // R6 wt miss no alloc
    '{1'b0, 1'b0, 1'b0, 32'h3000_0100, 32'h0,         2'd2, 32'h4444_4444, 4'd8, 4'd6},
    '{1'b1, 1'b0, 1'b0, 32'h5000_0204, 32'h5555_5555, 2'd0, 32'h0,         4'd8, 4'd6},  // R6 wb miss alloc
    '{1'b0, 1'b0, 1'b0, 32'h5000_0204, 32'h0,         2'd2, 32'h5555_5555, 4'd0, 4'd6}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat, cnt;
    string rq;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 ready", {31'd0, req_ready}, 32'd1);
    check("R12 mem_req", {31'd0, mem_req}, 32'd0);
    check("R12 resp", {31'd0, resp_valid}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 15; i++) begin
      rq = $sformatf("R%0d row%0d", VEC[i].rid, i);
      do_req(VEC[i].we, VEC[i].wt, VEC[i].ci, VEC[i].addr, VEC[i].wdata, rd, lat);
      check({rq, " beats"}, n_log, {28'd0, VEC[i].beats});
      if (VEC[i].emode == 2'd1) check({rq, " data"}, rd, init_val(VEC[i].addr));
      if (VEC[i].emode == 2'd2) check({rq, " data"}, rd, VEC[i].eval);
      if (VEC[i].beats == 4'd0 && !VEC[i].we) check({rq, " R3 latency"}, lat, 32'd2);
      if (VEC[i].beats == 4'd1 && VEC[i].we) begin
        check({rq, " single addr"}, log_addr[0], VEC[i].addr);
        check({rq, " single data"}, log_data[0], VEC[i].wdata);
      end
      if (i == 0)
        for (int b = 0; b < 8; b++)
          check("R2 burst addr", log_addr[b], 32'h0000_00A0 + 32'(4 * b));
      if (i == 2) check("R4 no mem write", wr_beats(), 32'd0);
    end

    // R8 R9 R10: set 2, tags 0..4
    rd_chk("R8 fill w0", 32'h0000_0040, init_val(32'h0000_0040), 8);
    rd_chk("R8 fill w1", 32'h0000_1040, init_val(32'h0000_1040), 8);
    rd_chk("R8 fill w2", 32'h0000_2040, init_val(32'h0000_2040), 8);
    do_req(1'b1, 1'b0, 1'b0, 32'h0000_2048, 32'h6666_6666, rd, lat);
    check("R4 dirty write no mem", n_log, 32'd0);
    rd_chk("R8 fill w3", 32'h0000_3040, init_val(32'h0000_3040), 8);
    rd_chk("R9 touch w0", 32'h0000_0040, init_val(32'h0000_0040), 0);
    // tree now points at way 2 (dirty)
    rd_chk("R10 evict", 32'h0000_4040, init_val(32'h0000_4040), 16);
    check("R10 wb beats", wr_beats(), 32'd8);
    check("R10 wb first addr", log_addr[0], 32'h0000_2040);
    check("R10 wb first we", {31'd0, log_we[0]}, 32'd1);
    check("R10 fill after wb", log_addr[8], 32'h0000_4040);
    check("R10 fill is read", {31'd0, log_we[8]}, 32'd0);
    check("R10 wb data", rd_mem(32'h0000_2048), 32'h6666_6666);
    rd_chk("R9 w0 kept", 32'h0000_0040, init_val(32'h0000_0040), 0);
    rd_chk("R9 w1 kept", 32'h0000_1040, init_val(32'h0000_1040), 0);
    rd_chk("R9 w3 kept", 32'h0000_3040, init_val(32'h0000_3040), 0);
    rd_chk("R9 victim gone", 32'h0000_2048, 32'h6666_6666, 8);

    // R5 R10: write-through keeps Exclusive, eviction writes nothing back
    rd_chk("R5 fill x0", 32'h0000_0120, init_val(32'h0000_0120), 8);
    do_req(1'b1, 1'b1, 1'b0, 32'h0000_0124, 32'h7777_7777, rd, lat);
    check("R5 wt beats", n_log, 32'd1);
    rd_chk("R5 fill x1", 32'h0000_1120, init_val(32'h0000_1120), 8);
    rd_chk("R5 fill x2", 32'h0000_2120, init_val(32'h0000_2120), 8);
    rd_chk("R5 fill x3", 32'h0000_3120, init_val(32'h0000_3120), 8);
    rd_chk("R10 clean evict", 32'h0000_4120, init_val(32'h0000_4120), 8);
    check("R10 clean no wb", wr_beats(), 32'd0);
    rd_chk("R5 memory has wt data", 32'h0000_0124, 32'h7777_7777, 8);

    // R11: invalidate sweep
    @(negedge clk);
    inv = 1'b1;
    @(negedge clk);
    inv = 1'b0;
    cnt = 0;
    #1;
    while (!req_ready && cnt < 1000) begin cnt++; @(negedge clk); #1; end
    check("R11 stall cycles", cnt, 32'd128);
    rd_chk("R11 dirty discarded", 32'h5000_0204, init_val(32'h5000_0204), 8);
    check("R11 no wb", wr_beats(), 32'd0);
    rd_chk("R11 clean gone", 32'h0000_00A4, init_val(32'h0000_00A4), 8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule